// File: doc/BRIEF.md
# Dithered Pulse-Width Modulator

This block generates several pulse-width modulated outputs. They share one timebase, and each channel has its own 8-bit setting. The input clock first passes through a power-of-two prescaler. A PWM cycle lasts 32 prescaled clocks, and eight cycles make up a frame. The upper five bits of a channel setting give the coarse high time. The lower three bits give how many cycles of each frame are stretched by one extra prescaled clock. Averaged over a frame, this gives 256 distinct duty levels.

The stretched cycles are spread through the frame rather than bunched together. A cycle is stretched when its index, with the three bits reversed, is below the insertion count. Software writes settings through a plain write strobe with an address and data. A new channel setting only takes effect at the next frame boundary, so a frame never mixes two settings.

Top module: `dpwm_top`

## Requirements
- R1: The control register at address 0 holds the prescaler select in bits 1:0. One prescaled clock lasts 2, 4, 8 or 16 input clocks for select values 0, 1, 2 and 3. A new select applies from the clock after the write.
- R2: A PWM cycle lasts 32 prescaled clocks and a frame lasts 8 cycles. The output goes high only at the first prescaled clock of a cycle and stays high for one contiguous run.
- R3: The channel k register sits at address k+1. Bits 7:3 hold the coarse duty D and bits 2:0 hold the insertion count N. The high time of a cycle is D+e prescaled clocks, where e is 0 or 1.
- R4: For the cycle with index c (0 to 7) in a frame, e is 1 exactly when the bit-reversed value of c is less than N.
- R5: With D=0 and N=0 the output stays low. With D=31, a stretched cycle is high for all 32 prescaled clocks.
- R6: A channel write changes nothing in the current frame. The new value governs every cycle from the start of the next frame.
- R7: Reset clears the control and channel registers, restarts the timebase at cycle 0, and holds every output low.
- R8: Channels are independent: each follows only its own register, and all share one prescaler and cycle position.
- R9: Writing 0x83 gives D=16 and N=3. Cycles 0, 4 and 2 of each frame are then high for 17 prescaled clocks and the others for 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address: 0 for control, k+1 for channel k |
| wr_data_i | input | 8 | Write data |
| pwm_o | output | NCH | PWM outputs, one bit per channel |

## Verification
The bench builds the block with NCH=2 and ADDR_W=2. The two channels run through complementary halves of the setting space at the fastest prescaler, so all 256 settings are measured cycle by cycle across full frames in about 66k clocks. That sweep covers both duty extremes and every insertion pattern. The bench then resets into each slower prescaler and checks a frame of high times scaled by 4, 8 and 16. A write made early in each frame shows whether the setting is held off until the following frame.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int DUTY_W = 5;
  localparam int INS_W  = 3;
  localparam int DATA_W = DUTY_W + INS_W;
  localparam int SEL_W  = 2;
  localparam int PCNT_W = 4;
  localparam int SLOT_W = DUTY_W;
  localparam int FRM_W  = INS_W;
  typedef logic [DATA_W-1:0] chan_cfg_t;
endpackage

// File: rtl/dpwm_prescaler.sv
module dpwm_prescaler
  import dpwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PCNT_W-1:0] cnt_q;
  logic [PCNT_W:0]   div_m1;

  assign div_m1 = ((PCNT_W+1)'(2) << sel_i) - (PCNT_W+1)'(1);
  // compare with >= so a smaller divide picked mid-count cannot overrun
  assign tick_o = {1'b0, cnt_q} >= div_m1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dpwm_timebase.sv
module dpwm_timebase
  import dpwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [FRM_W-1:0]  frame_o,
  output logic              frame_end_o
);
  logic slot_last;

  assign slot_last   = &slot_o;
  assign frame_end_o = tick_i && slot_last && (&frame_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_o  <= '0;
      frame_o <= '0;
    end else if (tick_i) begin
      slot_o <= slot_o + 1'b1;
      if (slot_last) frame_o <= frame_o + 1'b1;
    end
  end
endmodule

// File: rtl/dpwm_regs.sv
module dpwm_regs
  import dpwm_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [DATA_W-1:0]         wr_data_i,
  input  logic                      frame_end_i,
  output logic [SEL_W-1:0]          sel_o,
  output logic [NCH-1:0][DATA_W-1:0] act_o
);
  logic [NCH-1:0][DATA_W-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             sel_o <= '0;
    else if (wr_en_i && wr_addr_i == '0)     sel_o <= wr_data_i[SEL_W-1:0];
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    localparam logic [ADDR_W-1:0] ADDR_K = ADDR_W'(k + 1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            pend_q[k] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_K) pend_q[k] <= wr_data_i;
    end

    // shadow copy swaps only on the frame boundary
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          act_o[k] <= '0;
      else if (frame_end_i) act_o[k] <= pend_q[k];
    end
  end
endmodule

// File: rtl/dpwm_channel.sv
module dpwm_channel
  import dpwm_pkg::*;
(
  input  logic [DATA_W-1:0] cfg_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [FRM_W-1:0]  frame_i,
  output logic              pwm_o
);
  logic [DUTY_W-1:0] duty;
  logic [INS_W-1:0]  ins;
  logic [FRM_W-1:0]  frame_rev;
  logic              ext;
  logic [SLOT_W:0]   high_len;

  assign duty = cfg_i[DATA_W-1:INS_W];
  assign ins  = cfg_i[INS_W-1:0];

  for (genvar b = 0; b < FRM_W; b++) begin : g_rev
    assign frame_rev[b] = frame_i[FRM_W-1-b];
  end

  assign ext      = frame_rev < ins;
  assign high_len = {1'b0, duty} + {{SLOT_W{1'b0}}, ext};
  assign pwm_o    = {1'b0, slot_i} < high_len;
endmodule

// File: rtl/dpwm_top.sv
module dpwm_top
  import dpwm_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [NCH-1:0]    pwm_o
);
  logic                       tick;
  logic                       frame_end;
  logic [SEL_W-1:0]           sel;
  logic [SLOT_W-1:0]          slot;
  logic [FRM_W-1:0]           frame;
  logic [NCH-1:0][DATA_W-1:0] act;

  dpwm_prescaler u_pre (
    .clk_i (clk_i), .rst_ni (rst_ni), .sel_i (sel), .tick_o (tick)
  );

  dpwm_timebase u_tb (
    .clk_i (clk_i), .rst_ni (rst_ni), .tick_i (tick),
    .slot_o (slot), .frame_o (frame), .frame_end_o (frame_end)
  );

  dpwm_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .frame_end_i (frame_end),
    .sel_o       (sel),
    .act_o       (act)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    dpwm_channel u_ch (
      .cfg_i (act[k]), .slot_i (slot), .frame_i (frame), .pwm_o (pwm_o[k])
    );
  end
endmodule

// File: rtl/dpwm_checker.sv
module dpwm_checker
  import dpwm_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       tick_i,
  input logic [SLOT_W-1:0]          slot_i,
  input logic [FRM_W-1:0]           frame_i,
  input logic                       frame_end_i,
  input logic [NCH-1:0][DATA_W-1:0] act_i,
  input logic [NCH-1:0]             pwm_i
);
  logic [PCNT_W:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gap_q <= '0;
    else if (tick_i) gap_q <= '0;
    else             gap_q <= gap_q + 1'b1;
  end

  a_r1_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q < (PCNT_W+1)'(16));

  a_r2_slot_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> slot_i == $past(slot_i) + 1'b1);

  a_r2_slot_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(slot_i) && $stable(frame_i));

  a_r6_act_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> $stable(act_i));

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    a_r2_rise_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pwm_i[k]) |-> slot_i == '0);

    a_r5_zero_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_i[k] == '0 |-> !pwm_i[k]);
  end
endmodule

bind dpwm_top dpwm_checker #(.NCH(NCH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick),
  .slot_i      (slot),
  .frame_i     (frame),
  .frame_end_i (frame_end),
  .act_i       (act),
  .pwm_i       (pwm_o)
);

// File: tb/sim_dpwm_top.sv
module sim_dpwm_top;
  localparam int NCH    = 2;
  localparam int ADDR_W = 2;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0;
  logic [ADDR_W-1:0] wr_addr_i = '0;
  logic [7:0]        wr_data_i = '0;
  logic [NCH-1:0]    pwm_o;

  int checks = 0;
  int fails  = 0;
  int div_m  = 2;
  logic [7:0] act_m [NCH];
  logic [7:0] pend_m [NCH];

  dpwm_top #(.NCH(NCH), .ADDR_W(ADDR_W)) u0 (
    .clk_i (clk_i), .rst_ni (rst_ni), .wr_en_i (wr_en_i),
    .wr_addr_i (wr_addr_i), .wr_data_i (wr_data_i), .pwm_o (pwm_o)
  );

  always #2 clk_i = ~clk_i;

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  function automatic int exp_high(input logic [7:0] v, input int c);
    int rev;
    int n;
    int e;
    rev = ((c & 1) << 2) | (c & 2) | ((c >> 2) & 1);
    n   = int'(v[2:0]);
    e   = (rev < n) ? 1 : 0;
    return int'(v[7:3]) + e;
  endfunction

  // reset; leaves the bench at the first low-phase after release (cycle 0, slot 0)
  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    checks++;
    if (pwm_o !== '0) begin
      fails++;
      $display("FAIL R7 output during reset: actual=%b expected=%b", pwm_o, {NCH{1'b0}});
    end
    for (int k = 0; k < NCH; k++) begin
      act_m[k]  = '0;
      pend_m[k] = '0;
    end
    div_m  = 2;
    rst_ni = 1'b1;
  endtask

  // observe one whole frame; optionally write control and both channels early in it
  task automatic run_frame(input bit do_ctrl, input logic [1:0] sel,
                           input bit do_wr, input logic [7:0] w0, input logic [7:0] w1,
                           input string tag);
    int hcnt [NCH][8];
    bit bad  [NCH][8];
    if (do_ctrl) div_m = 2 << sel;
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < NCH; k++) begin
        hcnt[k][c] = 0;
        bad[k][c]  = 1'b0;
      end
      for (int i = 0; i < 32 * div_m; i++) begin
        for (int k = 0; k < NCH; k++) begin
          logic exp_bit;
          exp_bit = (i < div_m * exp_high(act_m[k], c));
          if (pwm_o[k]) hcnt[k][c]++;
          if (pwm_o[k] !== exp_bit) bad[k][c] = 1'b1;
        end
        wr_en_i = 1'b0;
        if (c == 0 && i == 0 && do_ctrl) begin
          wr_en_i = 1'b1; wr_addr_i = '0; wr_data_i = {6'd0, sel};
        end
        if (c == 0 && i == 1 && do_wr) begin
          wr_en_i = 1'b1; wr_addr_i = ADDR_W'(1); wr_data_i = w0; pend_m[0] = w0;
        end
        if (c == 0 && i == 2 && do_wr) begin
          wr_en_i = 1'b1; wr_addr_i = ADDR_W'(2); wr_data_i = w1; pend_m[1] = w1;
        end
        @(negedge clk_i);
      end
    end
    for (int k = 0; k < NCH; k++) begin
      for (int c = 0; c < 8; c++) begin
        checks++;
        if (bad[k][c]) begin
          fails++;
          $display("FAIL %s ch%0d cfg=%h cycle %0d: actual high=%0d expected high=%0d clocks",
                   tag, k, act_m[k], c, hcnt[k][c], div_m * exp_high(act_m[k], c));
        end
      end
    end
    for (int k = 0; k < NCH; k++) act_m[k] = pend_m[k];
  endtask

  initial begin
    do_reset();
    // R7: first frame after reset runs with cleared settings; R6: writes here wait
    run_frame(1'b0, 2'd0, 1'b1, 8'h83, 8'hF9, "R7 R6");
    // R9 on ch0, R5 full-high stretched cycles on ch1
    run_frame(1'b0, 2'd0, 1'b1, 8'h00, 8'hFF, "R9 R5 R8");
    // R3 R4 R5 R6 R8: sweep all 256 settings across two channels
    for (int v = 0; v < 128; v++)
      run_frame(1'b0, 2'd0, 1'b1, 8'(v), 8'(255 - v), "R3 R4 R5 R6 R8");
    run_frame(1'b0, 2'd0, 1'b0, 8'h00, 8'h00, "R3 R4");
    // R1: remaining prescaler settings
    for (int s = 1; s < 4; s++) begin
      do_reset();
      run_frame(1'b1, 2'(s), 1'b1, 8'h83, 8'hFF, "R1 R7");
      run_frame(1'b0, 2'(s), 1'b1, 8'h4A, 8'h07, "R1 R2 R9");
      run_frame(1'b0, 2'(s), 1'b0, 8'h00, 8'h00, "R1 R2");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule